// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of recent virtual-to-physical translations that sits in front of a hardware page table walker. A lookup presents a virtual page number together with the current address-space identifier, the access kind (read, write or execute) and whether the access comes from user mode. In the same cycle the block either returns the physical frame number, reports a permission fault, or raises a miss request. On a miss the walker fetches the mapping and writes it back through the refill port. The new entry can be used from the next cycle.

Every entry carries an address-space identifier, so a context switch does not need a full flush. An entry marked global matches under any identifier. Entries can cover a 4 KB, 2 MB or 1 GB page. For the larger pages, fewer page-number bits take part in the match, and the low virtual page bits are passed straight through into the returned frame number. A maintenance port removes the entries for one page, the entries for one address space, or every entry. A replacement pointer first fills empty slots and then evicts entries in round-robin order.

Top module: `asid_tlb`

## Requirements
- R1: A lookup whose page number and identifier match a stored 4 KB entry, and whose access is allowed, asserts `lk_hit` in the same cycle with `lk_ppn` equal to the stored frame number.
- R2: A non-global entry matches only a lookup that carries the same identifier. A global entry matches a lookup under any identifier.
- R3: `rf_size` uses the encoding 0 = 4 KB, 1 = 2 MB, 2 = 1 GB. A 2 MB entry ignores the low 9 page-number bits and a 1 GB entry ignores the low 18 page-number bits when matching. Those ignored bits of the lookup replace the same bits of the returned frame number.
- R4: A hit raises `lk_fault` instead of `lk_hit` in any of these cases: a write to an entry that is not writable, a user-mode access to a supervisor-only entry, or an execute access to a no-execute entry.
- R5: A write that is allowed but hits an entry whose dirty flag is clear raises `miss_req`, so that the walker updates the dirty bit in memory.
- R6: `miss_req` is raised when no entry matches. At most one of `lk_hit`, `lk_fault` and `miss_req` is high at a time. All three are low when `lk_valid` is low.
- R7: `inv_op` uses the encoding 0 = none, 1 = page, 2 = address space, 3 = all. A page invalidate removes every entry that maps `inv_vpn`, whatever its identifier or page size.
- R8: An address-space invalidate removes every non-global entry whose identifier equals `inv_asid`. Global entries and entries of other identifiers stay.
- R9: A full invalidate removes every entry and returns the replacement pointer to slot 0.
- R10: A refill is visible from the next cycle. A refill whose page, size, identifier and global flag equal those of a stored entry overwrites that entry instead of taking a new slot.
- R11: A new refill goes to the first empty slot at or after the replacement pointer. If there is no empty slot, it goes to the slot under the pointer. After the install, the pointer moves to the slot after the one written.
- R12: When a refill and an invalidate happen in the same cycle, the invalidate is applied and the refill is dropped if the invalidate would have removed it. Otherwise the refill is installed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Lookup is a write |
| lk_exec | input | 1 | Lookup is an instruction fetch |
| lk_user | input | 1 | Lookup comes from user mode |
| lk_hit | output | 1 | Translation is valid and permitted |
| lk_fault | output | 1 | Permission fault on a matching entry |
| miss_req | output | 1 | Request to the page table walker |
| lk_ppn | output | PPN_W | Physical frame number, valid with lk_hit |
| rf_valid | input | 1 | Walker refill strobe |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_asid | input | ASID_W | Refill identifier |
| rf_ppn | input | PPN_W | Refill frame number |
| rf_size | input | 2 | Refill page size (0 = 4 KB, 1 = 2 MB, 2 = 1 GB) |
| rf_global | input | 1 | Entry matches any identifier |
| rf_writable | input | 1 | Entry allows writes |
| rf_user | input | 1 | Entry allows user access |
| rf_nx | input | 1 | Entry forbids execution |
| rf_dirty | input | 1 | Page already marked dirty |
| inv_op | input | 2 | Maintenance command (0 none, 1 page, 2 space, 3 all) |
| inv_vpn | input | VPN_W | Page to invalidate |
| inv_asid | input | ASID_W | Identifier to invalidate |

## Verification
The bench targets the cases that are easy to get wrong:
- **Large pages.** Lookups at both edges of a 2 MB region and inside a 1 GB region. A wrong match mask would give false hits just outside the region, and a wrong pass-through would give the wrong frame.
- **Identifiers and the global flag.** A design that ignores the identifier, or does not exempt global entries from an address-space invalidate, would hit where a miss is expected, or lose a global mapping.
- **Dirty-bit misses.** A write to a clean page must become a miss; a design that returned a hit would never get the dirty bit set in memory.
- **Refill-over-existing.** A rewrite of an existing page must replace the old entry; a design that added a duplicate would keep returning the stale frame.
- **Same-cycle refill and invalidate.** A refill that the invalidate covers must be dropped, while an unrelated refill must still be installed.
- **Replacement order.** Filling the whole array and then evicting shows whether the pointer takes empty slots first and advances past the slot it wrote.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    MAINT_NONE  = 2'd0,
    MAINT_PAGE  = 2'd1,
    MAINT_SPACE = 2'd2,
    MAINT_ALL   = 2'd3
  } maint_op_e;

  typedef enum logic [1:0] {
    SZ_4K = 2'd0,
    SZ_2M = 2'd1,
    SZ_1G = 2'd2
  } page_size_e;

endpackage

// File: rtl/tlb_match.sv
// Per-entry comparator: lookup hit and refill-collision detection.
module tlb_match
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 27,
  parameter int ASID_W = 8,
  parameter int LVL_W  = 9
) (
  input  logic              e_vld,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [1:0]        e_size,
  input  logic              e_g,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [1:0]        rf_size,
  input  logic              rf_g,
  output logic              lk_match,
  output logic              rf_same
);
  localparam logic [VPN_W-1:0] M_ALL = {VPN_W{1'b1}};
  localparam logic [VPN_W-1:0] M_2M  = M_ALL << LVL_W;
  localparam logic [VPN_W-1:0] M_1G  = M_ALL << (2 * LVL_W);

  logic [VPN_W-1:0] cmp_mask;

  always_comb begin
    case (page_size_e'(e_size))
      SZ_2M:   cmp_mask = M_2M;
      SZ_1G:   cmp_mask = M_1G;
      default: cmp_mask = M_ALL;
    endcase
  end

  assign lk_match = e_vld && (((e_vpn ^ lk_vpn) & cmp_mask) == '0)
                    && (e_g || (e_asid == lk_asid));

  assign rf_same  = e_vld && (e_size == rf_size) && (e_g == rf_g)
                    && (((e_vpn ^ rf_vpn) & cmp_mask) == '0)
                    && (e_g || (e_asid == rf_asid));
endmodule

// File: rtl/tlb_kill.sv
// Decides whether a maintenance command removes a given (stored or incoming) entry.
module tlb_kill
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 27,
  parameter int ASID_W = 8,
  parameter int LVL_W  = 9
) (
  input  logic              e_vld,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [1:0]        e_size,
  input  logic              e_g,
  input  logic [1:0]        op,
  input  logic [VPN_W-1:0]  op_vpn,
  input  logic [ASID_W-1:0] op_asid,
  output logic              kill
);
  localparam logic [VPN_W-1:0] M_ALL = {VPN_W{1'b1}};
  localparam logic [VPN_W-1:0] M_2M  = M_ALL << LVL_W;
  localparam logic [VPN_W-1:0] M_1G  = M_ALL << (2 * LVL_W);

  logic [VPN_W-1:0] cmp_mask;

  always_comb begin
    case (page_size_e'(e_size))
      SZ_2M:   cmp_mask = M_2M;
      SZ_1G:   cmp_mask = M_1G;
      default: cmp_mask = M_ALL;
    endcase
  end

  always_comb begin
    kill = 1'b0;
    if (e_vld) begin
      case (maint_op_e'(op))
        MAINT_PAGE:  kill = (((e_vpn ^ op_vpn) & cmp_mask) == '0);
        MAINT_SPACE: kill = !e_g && (e_asid == op_asid);
        MAINT_ALL:   kill = 1'b1;
        default:     kill = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tlb_victim.sv
// Replacement choice: first empty slot from the pointer, else the pointer itself.
module tlb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] slot_vld,
  input  logic [IDX_W-1:0]   ptr,
  output logic [IDX_W-1:0]   victim
);
  logic found;

  always_comb begin
    victim = ptr;
    found  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      int j;
      j = int'(ptr) + i;
      if (j >= ENTRIES) j = j - ENTRIES;
      if (!found && !slot_vld[j]) begin
        found  = 1'b1;
        victim = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 28,
  parameter int ASID_W  = 8,
  parameter int LVL_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_exec,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic              miss_req,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [1:0]        rf_size,
  input  logic              rf_global,
  input  logic              rf_writable,
  input  logic              rf_user,
  input  logic              rf_nx,
  input  logic              rf_dirty,
  input  logic [1:0]        inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [PPN_W-1:0] LO_2M = {{(PPN_W-LVL_W){1'b0}}, {LVL_W{1'b1}}};
  localparam logic [PPN_W-1:0] LO_1G = {{(PPN_W-2*LVL_W){1'b0}}, {(2*LVL_W){1'b1}}};

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Entry storage
  logic [ENTRIES-1:0] e_vld_q, e_vld_d;
  logic [VPN_W-1:0]   e_vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  e_asid_q [ENTRIES];
  logic [PPN_W-1:0]   e_ppn_q  [ENTRIES];
  logic [1:0]         e_size_q [ENTRIES];
  logic               e_g_q    [ENTRIES];
  logic               e_w_q    [ENTRIES];
  logic               e_u_q    [ENTRIES];
  logic               e_nx_q   [ENTRIES];
  logic               e_d_q    [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;

  logic [ENTRIES-1:0] hit_vec, same_vec, kill_vec, wr_en;
  logic               rf_killed;
  logic [IDX_W-1:0]   victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W)) u_match (
      .e_vld(e_vld_q[g]), .e_vpn(e_vpn_q[g]), .e_asid(e_asid_q[g]),
      .e_size(e_size_q[g]), .e_g(e_g_q[g]),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_size(rf_size), .rf_g(rf_global),
      .lk_match(hit_vec[g]), .rf_same(same_vec[g])
    );
    tlb_kill #(.VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W)) u_kill (
      .e_vld(e_vld_q[g]), .e_vpn(e_vpn_q[g]), .e_asid(e_asid_q[g]),
      .e_size(e_size_q[g]), .e_g(e_g_q[g]),
      .op(inv_op), .op_vpn(inv_vpn), .op_asid(inv_asid),
      .kill(kill_vec[g])
    );
  end

  // The incoming refill is tested against the same command.
  tlb_kill #(.VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W)) u_rf_kill (
    .e_vld(rf_valid), .e_vpn(rf_vpn), .e_asid(rf_asid),
    .e_size(rf_size), .e_g(rf_global),
    .op(inv_op), .op_vpn(inv_vpn), .op_asid(inv_asid),
    .kill(rf_killed)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .slot_vld(e_vld_q), .ptr(rr_q), .victim(victim)
  );

  // Lowest-index match wins for lookup and for refill collision.
  logic             hit_any, same_any;
  logic [IDX_W-1:0] hit_idx, same_idx;
  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    same_any = 1'b0;
    same_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] && !hit_any) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (same_vec[i] && !same_any) begin
        same_any = 1'b1;
        same_idx = IDX_W'(i);
      end
    end
  end

  // Lookup result
  logic             perm_bad, clean_wr;
  logic [PPN_W-1:0] lo_bits, s_ppn;
  assign perm_bad = (lk_write && !e_w_q[hit_idx]) || (lk_user && !e_u_q[hit_idx])
                    || (lk_exec && e_nx_q[hit_idx]);
  assign clean_wr = lk_write && !e_d_q[hit_idx];
  assign lk_fault = lk_valid && hit_any && perm_bad;
  assign lk_hit   = lk_valid && hit_any && !perm_bad && !clean_wr;
  assign miss_req = lk_valid && (!hit_any || (!perm_bad && clean_wr));

  assign lo_bits = PPN_W'(lk_vpn[2*LVL_W-1:0]);
  assign s_ppn   = e_ppn_q[hit_idx];
  always_comb begin
    case (page_size_e'(e_size_q[hit_idx]))
      SZ_2M:   lk_ppn = (s_ppn & ~LO_2M) | (lo_bits & LO_2M);
      SZ_1G:   lk_ppn = (s_ppn & ~LO_1G) | (lo_bits & LO_1G);
      default: lk_ppn = s_ppn;
    endcase
  end

  // Next state
  logic             do_inst;
  logic [IDX_W-1:0] ins_idx;
  assign do_inst = rf_valid && !rf_killed;
  assign ins_idx = same_any ? same_idx : victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_wen
    assign wr_en[g] = do_inst && (ins_idx == IDX_W'(g));
  end

  always_comb begin
    e_vld_d = (e_vld_q & ~kill_vec) | wr_en;
    rr_d    = rr_q;
    if (maint_op_e'(inv_op) == MAINT_ALL)
      rr_d = '0;
    else if (do_inst && !same_any)
      rr_d = (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      e_vld_q <= '0;
      rr_q    <= '0;
    end else begin
      e_vld_q <= e_vld_d;
      rr_q    <= rr_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        e_vpn_q[g]  <= rf_vpn;
        e_asid_q[g] <= rf_asid;
        e_ppn_q[g]  <= rf_ppn;
        e_size_q[g] <= rf_size;
        e_g_q[g]    <= rf_global;
        e_w_q[g]    <= rf_writable;
        e_u_q[g]    <= rf_user;
        e_nx_q[g]   <= rf_nx;
        e_d_q[g]    <= rf_dirty;
      end
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VPN_W  = 27,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_write,
  input logic              lk_exec,
  input logic              lk_hit,
  input logic              lk_fault,
  input logic              miss_req,
  input logic              rf_valid,
  input logic [VPN_W-1:0]  rf_vpn,
  input logic [ASID_W-1:0] rf_asid,
  input logic [1:0]        inv_op,
  input logic [VPN_W-1:0]  inv_vpn
);
  // R6: outcomes are exclusive
  p_excl_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_fault, miss_req}));

  // R6: silent without a lookup
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_fault || miss_req));

  // R9: nothing matches after a full flush
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_op == 2'd3) |=> !(lk_hit || lk_fault));

  // R7: the invalidated page no longer matches
  p_page_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_op == 2'd1) |=>
      !(lk_valid && (lk_vpn == $past(inv_vpn)) && (lk_hit || lk_fault)));

  // R10: a refill serves a plain read in the next cycle
  p_refill_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && inv_op == 2'd0) |=>
      (!(lk_valid && lk_vpn == $past(rf_vpn) && lk_asid == $past(rf_asid)
         && !lk_write && !lk_exec) || !miss_req));
endmodule

bind asid_tlb asid_tlb_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (.*);

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
  localparam int VPN_W = 27, PPN_W = 28, ASID_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic lk_valid, lk_write, lk_exec, lk_user;
  logic [VPN_W-1:0] lk_vpn;
  logic [ASID_W-1:0] lk_asid;
  logic lk_hit, lk_fault, miss_req;
  logic [PPN_W-1:0] lk_ppn;
  logic rf_valid, rf_global, rf_writable, rf_user, rf_nx, rf_dirty;
  logic [VPN_W-1:0] rf_vpn;
  logic [ASID_W-1:0] rf_asid;
  logic [PPN_W-1:0] rf_ppn;
  logic [1:0] rf_size, inv_op;
  logic [VPN_W-1:0] inv_vpn;
  logic [ASID_W-1:0] inv_asid;

  asid_tlb u_dut (.*);

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              wr, ex, us;
    logic [2:0]        exp;   // {hit, fault, miss}
    logic [PPN_W-1:0]  ppn;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{27'h0000123, 8'd1, 1'b0, 1'b0, 1'b1, 3'b100, 28'h00ABCDE, 4'd1},  // R1 read hit
    '{27'h0000123, 8'd2, 1'b0, 1'b0, 1'b1, 3'b001, 28'h0,       4'd2},  // R2 wrong identifier
    '{27'h0000123, 8'd1, 1'b1, 1'b0, 1'b1, 3'b100, 28'h00ABCDE, 4'd1},  // R1 write hit, dirty
    '{27'h0000200, 8'd1, 1'b0, 1'b0, 1'b1, 3'b100, 28'h0000042, 4'd1},  // R1
    '{27'h0000200, 8'd1, 1'b1, 1'b0, 1'b1, 3'b010, 28'h0,       4'd4},  // R4 write read-only
    '{27'h0000200, 8'd1, 1'b0, 1'b1, 1'b1, 3'b010, 28'h0,       4'd4},  // R4 exec no-exec
    '{27'h0000300, 8'd2, 1'b0, 1'b0, 1'b1, 3'b010, 28'h0,       4'd4},  // R4 user on supervisor
    '{27'h0000300, 8'd2, 1'b0, 1'b0, 1'b0, 3'b100, 28'h0000777, 4'd1},  // R1
    '{27'h0000300, 8'd2, 1'b1, 1'b0, 1'b0, 3'b001, 28'h0,       4'd5},  // R5 clean write
    '{27'h00015AB, 8'd9, 1'b0, 1'b0, 1'b1, 3'b100, 28'h00123AB, 4'd3},  // R3 2M global
    '{27'h00015FF, 8'd0, 1'b0, 1'b0, 1'b1, 3'b100, 28'h00123FF, 4'd3},  // R3 top edge
    '{27'h0001600, 8'd5, 1'b0, 1'b0, 1'b1, 3'b001, 28'h0,       4'd3},  // R3 past edge
    '{27'h00AABCD, 8'd3, 1'b0, 1'b0, 1'b1, 3'b100, 28'h012ABCD, 4'd3},  // R3 1G
    '{27'h00AABCD, 8'd3, 1'b0, 1'b1, 1'b1, 3'b010, 28'h0,       4'd4},  // R4 1G no-exec
    '{27'h00AABCD, 8'd4, 1'b0, 1'b0, 1'b1, 3'b001, 28'h0,       4'd2}   // R2
  };

  task automatic idle_inputs();
    lk_valid = 0; lk_write = 0; lk_exec = 0; lk_user = 0; lk_vpn = '0; lk_asid = '0;
    rf_valid = 0; rf_vpn = '0; rf_asid = '0; rf_ppn = '0; rf_size = 0;
    rf_global = 0; rf_writable = 0; rf_user = 0; rf_nx = 0; rf_dirty = 0;
    inv_op = 0; inv_vpn = '0; inv_asid = '0;
  endtask

  task automatic set_refill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                            input logic [PPN_W-1:0] p, input logic [1:0] sz,
                            input logic g, w, u, nx, d);
    rf_valid = 1; rf_vpn = v; rf_asid = a; rf_ppn = p; rf_size = sz;
    rf_global = g; rf_writable = w; rf_user = u; rf_nx = nx; rf_dirty = d;
  endtask

  task automatic refill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        input logic [PPN_W-1:0] p, input logic [1:0] sz,
                        input logic g, w, u, nx, d);
    @(negedge clk);
    set_refill(v, a, p, sz, g, w, u, nx, d);
    @(negedge clk);
    rf_valid = 0;
  endtask

  task automatic maint(input logic [1:0] op, input logic [VPN_W-1:0] v,
                       input logic [ASID_W-1:0] a);
    @(negedge clk);
    inv_op = op; inv_vpn = v; inv_asid = a;
    @(negedge clk);
    inv_op = 0;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic wr, ex, us, input logic [2:0] exp,
                      input logic [PPN_W-1:0] eppn, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_write = wr; lk_exec = ex; lk_user = us;
    #1;
    checks++;
    if ({lk_hit, lk_fault, miss_req} !== exp || (exp[2] && lk_ppn !== eppn)) begin
      errors++;
      $display("FAIL %s: hit/fault/miss=%b ppn=%h expected %b ppn=%h",
               tag, {lk_hit, lk_fault, miss_req}, lk_ppn, exp, eppn);
    end
    @(negedge clk);
    lk_valid = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R6: reset state, empty array misses
    look(27'h123, 8'd1, 0, 0, 1, 3'b001, '0, "R6 reset miss");

    // Setup entries
    refill(27'h0000123, 8'd1, 28'h00ABCDE, 2'd0, 0, 1, 1, 0, 1);
    refill(27'h0000200, 8'd1, 28'h0000042, 2'd0, 0, 0, 1, 1, 0);
    refill(27'h0000300, 8'd2, 28'h0000777, 2'd0, 0, 1, 0, 0, 0);
    refill(27'h0001400, 8'd5, 28'h0012200, 2'd1, 1, 1, 1, 0, 1);
    refill(27'h0080000, 8'd3, 28'h0100000, 2'd2, 0, 1, 1, 1, 1);

    for (int k = 0; k < NV; k++) begin
      string t;
      t = $sformatf("R%0d vector %0d", VT[k].req, k);
      look(VT[k].vpn, VT[k].asid, VT[k].wr, VT[k].ex, VT[k].us, VT[k].exp, VT[k].ppn, t);
    end

    // R10: refill of an existing page overwrites it
    refill(27'h0000300, 8'd2, 28'h0000778, 2'd0, 0, 1, 0, 0, 1);
    look(27'h300, 8'd2, 1, 0, 0, 3'b100, 28'h0000778, "R10 overwrite");

    // R8: identifier invalidate spares global entries
    maint(2'd2, '0, 8'd5);
    look(27'h1450, 8'd9, 0, 0, 1, 3'b100, 28'h0012250, "R8 global kept");
    maint(2'd2, '0, 8'd1);
    look(27'h123, 8'd1, 0, 0, 1, 3'b001, '0, "R8 space removed");
    look(27'h200, 8'd1, 0, 0, 1, 3'b001, '0, "R8 space removed 2");
    look(27'h300, 8'd2, 0, 0, 0, 3'b100, 28'h0000778, "R8 other space kept");

    // R7: page invalidate inside a 2M entry
    maint(2'd1, 27'h1450, 8'd0);
    look(27'h1400, 8'd5, 0, 0, 1, 3'b001, '0, "R7 large page removed");
    look(27'hAABCD, 8'd3, 0, 0, 1, 3'b100, 28'h012ABCD, "R7 other kept");

    // R12: refill and invalidate together
    @(negedge clk);
    set_refill(27'h500, 8'd1, 28'h55, 2'd0, 0, 1, 1, 0, 1);
    inv_op = 2'd1; inv_vpn = 27'h500;
    @(negedge clk);
    rf_valid = 0; inv_op = 0;
    look(27'h500, 8'd1, 0, 0, 1, 3'b001, '0, "R12 refill dropped");
    @(negedge clk);
    set_refill(27'h600, 8'd1, 28'h66, 2'd0, 0, 1, 1, 0, 1);
    inv_op = 2'd1; inv_vpn = 27'h700;
    @(negedge clk);
    rf_valid = 0; inv_op = 0;
    look(27'h600, 8'd1, 0, 0, 1, 3'b100, 28'h66, "R12 refill kept");
    @(negedge clk);
    set_refill(27'h800, 8'd4, 28'h88, 2'd0, 0, 1, 1, 0, 1);
    inv_op = 2'd2; inv_asid = 8'd4;
    @(negedge clk);
    rf_valid = 0; inv_op = 0;
    look(27'h800, 8'd4, 0, 0, 1, 3'b001, '0, "R12 space drop");

    // R9: full flush
    maint(2'd3, '0, '0);
    look(27'hAABCD, 8'd3, 0, 0, 1, 3'b001, '0, "R9 flush 1G");
    look(27'h600, 8'd1, 0, 0, 1, 3'b001, '0, "R9 flush 4K");

    // R11: replacement order (pointer back at 0 after flush, per R9)
    for (int i = 0; i < 64; i++)
      refill(27'h1000 + i, 8'd7, 28'h5000 + i, 2'd0, 0, 1, 1, 0, 1);
    look(27'h1000, 8'd7, 0, 0, 1, 3'b100, 28'h5000, "R11 full first");
    look(27'h103F, 8'd7, 0, 0, 1, 3'b100, 28'h503F, "R11 full last");
    refill(27'h2000, 8'd7, 28'h6000, 2'd0, 0, 1, 1, 0, 1);
    look(27'h1000, 8'd7, 0, 0, 1, 3'b001, '0, "R11 slot0 evicted");
    look(27'h1001, 8'd7, 0, 0, 1, 3'b100, 28'h5001, "R11 slot1 kept");
    look(27'h2000, 8'd7, 0, 0, 1, 3'b100, 28'h6000, "R11 new entry");
    maint(2'd1, 27'h1005, '0);
    refill(27'h2001, 8'd7, 28'h6001, 2'd0, 0, 1, 1, 0, 1);
    look(27'h1001, 8'd7, 0, 0, 1, 3'b100, 28'h5001, "R11 empty slot first");
    look(27'h2001, 8'd7, 0, 0, 1, 3'b100, 28'h6001, "R11 empty slot used");
    refill(27'h2002, 8'd7, 28'h6002, 2'd0, 0, 1, 1, 0, 1);
    look(27'h1006, 8'd7, 0, 0, 1, 3'b001, '0, "R11 pointer past slot5");
    look(27'h1002, 8'd7, 0, 0, 1, 3'b100, 28'h5002, "R11 slot2 kept");

    // R6: no lookup, no outcome
    @(negedge clk);
    #1;
    checks++;
    if (lk_hit || lk_fault || miss_req) begin
      errors++;
      $display("FAIL R6 idle: outputs=%b expected 000", {lk_hit, lk_fault, miss_req});
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule